// File: doc/BRIEF.md
# Linked-List Pointer Walker

This block is the front stage of a decoupled streaming pipeline that visits a fixed number of singly linked lists. When started, it reads the first-node pointer of each list from a table in memory, one list at a time and in index order. It then follows the chain of nodes until it reads a null (zero) pointer. For every node it meets, it hands the node's value address to a downstream fetch stage on one stream. On a second stream it sends a one-bit control tag, and downstream stages use that tag to rebuild the loop structure without sharing a scheduler with this stage.

Each node takes two memory words. The value word is at the node pointer itself, and the successor pointer is at the pointer plus `NEXT_OFS`. Memory is read through a request/response port whose latency can vary, and the block keeps at most one read in flight. Each output stream is buffered by a small FIFO with a valid/ready interface. A full FIFO stalls only this stage. A single-cycle `done` pulse marks the end of a walk, once every tag has been taken.

Top module: `list_walker`

## Requirements
- R1: In the cycle after reset is released, `mem_req_valid`, `addr_valid`, `tag_valid` and `done` are all low.
- R2: After `start`, the list-table entries are read in ascending order at addresses `HEAD_BASE + i`, for i = 0 to `NUM_LISTS-1`. Each entry is read exactly once per walk.
- R3: For every non-zero pointer p that is read, the block delivers p once on the address stream and the tag value 1 ("continue") once on the tag stream.
- R4: After a node p has been emitted, the next read goes to address `p + NEXT_OFS`, and the returned word becomes the new current pointer.
- R5: A zero pointer (empty list or end of list) produces the tag value 0 ("exit") and no address. The next read is then the following list-table entry, or none after the last list.
- R6: At most one memory read is outstanding. No new request is made between an accepted request and its response.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and `mem_req_addr` does not change.
- R8: Each output stream holds its valid and data stable while it is not accepted. No item is lost or duplicated under any pattern of stalls.
- R9: `done` is a single-cycle pulse. It is raised only after the exit tag of the last list has been accepted, and only when both output streams are empty. It pulses exactly once per walk.
- R10: `start` is ignored while a walk is in progress. After `done`, no memory request is made until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk of all lists (only honoured when idle) |
| done | output | 1 | One-cycle pulse when the walk is finished and drained |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Word address to read |
| mem_rsp_valid | input | 1 | Read data is valid (one cycle per request) |
| mem_rsp_data | input | ADDR_W | Read data (a pointer word) |
| addr_valid | output | 1 | Value-address stream valid |
| addr_ready | input | 1 | Value-address stream accepted |
| addr_data | output | ADDR_W | Address of a node's value word |
| tag_valid | output | 1 | Tag stream valid |
| tag_ready | input | 1 | Tag stream accepted |
| tag_data | output | 1 | 1 = continue (a node follows), 0 = exit (list ended) |

## Verification
A corrupted current pointer shows at the ports within a few cycles. The next memory request address and the next value address both differ from the ones a behavioural walk of the same memory image predicts. A lost exit or continue decision shows as a tag sequence that is out of step on the very next accepted tag. A wrong list index shows as a wrong list-table read address, or as a `done` that comes too early or too late. Any FIFO pointer or count fault shows as a repeated, missing or changed item under the random stall patterns, and it is caught on the handshake where it occurs.

// File: rtl/list_walker_pkg.sv
package list_walker_pkg;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_REQ,
    WK_WAIT,
    WK_EMIT,
    WK_EXIT,
    WK_FINISH
  } walk_state_t;

  localparam logic TAG_CONTINUE = 1'b1;
  localparam logic TAG_EXIT     = 1'b0;

endpackage

// File: rtl/lw_fifo.sv
module lw_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  output logic             full,
  output logic             empty,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign out_valid = !empty;
  assign out_data  = store[rd_ptr];
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/lw_walk_ctrl.sv
module lw_walk_ctrl
  import list_walker_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_LISTS = 4,
  parameter int HEAD_BASE = 0,
  parameter int NEXT_OFS  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic              addr_full,
  input  logic              tag_full,
  input  logic              addr_empty,
  input  logic              tag_empty,
  output logic              addr_push,
  output logic [ADDR_W-1:0] addr_push_data,
  output logic              tag_push,
  output logic              tag_push_data
);
  localparam int IDX_W = $clog2(NUM_LISTS + 1);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_LISTS - 1);
  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(HEAD_BASE);
  localparam logic [ADDR_W-1:0] OFS_A    = ADDR_W'(NEXT_OFS);

  walk_state_t       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              done_q;
  logic              emit_ok, exit_ok;

  assign emit_ok = (state_q == WK_EMIT) && !addr_full && !tag_full;
  assign exit_ok = (state_q == WK_EXIT) && !tag_full;

  assign mem_req_valid  = (state_q == WK_REQ);
  assign mem_req_addr   = req_addr_q;
  assign addr_push      = emit_ok;
  assign addr_push_data = ptr_q;
  assign tag_push       = emit_ok || exit_ok;
  assign tag_push_data  = emit_ok ? TAG_CONTINUE : TAG_EXIT;
  assign done           = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= WK_IDLE;
      idx_q      <= '0;
      ptr_q      <= '0;
      req_addr_q <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        WK_IDLE: begin
          if (start) begin
            idx_q      <= '0;
            req_addr_q <= BASE_A;
            state_q    <= WK_REQ;
          end
        end
        WK_REQ: begin
          if (mem_req_ready) state_q <= WK_WAIT;
        end
        WK_WAIT: begin
          if (mem_rsp_valid) begin
            ptr_q   <= mem_rsp_data;
            state_q <= (mem_rsp_data != '0) ? WK_EMIT : WK_EXIT;
          end
        end
        WK_EMIT: begin
          if (emit_ok) begin
            req_addr_q <= ptr_q + OFS_A;
            state_q    <= WK_REQ;
          end
        end
        WK_EXIT: begin
          if (exit_ok) begin
            if (idx_q == LAST_IDX) begin
              state_q <= WK_FINISH;
            end else begin
              idx_q      <= idx_q + 1'b1;
              req_addr_q <= BASE_A + ADDR_W'(idx_q) + ADDR_W'(1);
              state_q    <= WK_REQ;
            end
          end
        end
        WK_FINISH: begin
          if (addr_empty && tag_empty) begin
            done_q  <= 1'b1;
            state_q <= WK_IDLE;
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/list_walker.sv
module list_walker #(
  parameter int ADDR_W     = 16,
  parameter int NUM_LISTS  = 4,
  parameter int HEAD_BASE  = 0,
  parameter int NEXT_OFS   = 1,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_data,
  output logic              tag_valid,
  input  logic              tag_ready,
  output logic              tag_data
);
  logic              addr_full, addr_empty, tag_full, tag_empty;
  logic              addr_push, tag_push, tag_push_data;
  logic [ADDR_W-1:0] addr_push_data;

  lw_walk_ctrl #(
    .ADDR_W(ADDR_W), .NUM_LISTS(NUM_LISTS),
    .HEAD_BASE(HEAD_BASE), .NEXT_OFS(NEXT_OFS)
  ) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .addr_full(addr_full), .tag_full(tag_full),
    .addr_empty(addr_empty), .tag_empty(tag_empty),
    .addr_push(addr_push), .addr_push_data(addr_push_data),
    .tag_push(tag_push), .tag_push_data(tag_push_data)
  );

  lw_fifo #(.WIDTH(ADDR_W), .DEPTH(FIFO_DEPTH)) addr_q_i (
    .clk(clk), .rst(rst), .push(addr_push), .push_data(addr_push_data),
    .full(addr_full), .empty(addr_empty), .out_valid(addr_valid),
    .out_ready(addr_ready), .out_data(addr_data)
  );

  lw_fifo #(.WIDTH(1), .DEPTH(FIFO_DEPTH)) tag_q_i (
    .clk(clk), .rst(rst), .push(tag_push), .push_data(tag_push_data),
    .full(tag_full), .empty(tag_empty), .out_valid(tag_valid),
    .out_ready(tag_ready), .out_data(tag_data)
  );

endmodule

// File: rtl/list_walker_chk.sv
module list_walker_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr_data,
  input logic              tag_valid,
  input logic              tag_ready,
  input logic              tag_data
);
  logic in_flight;

  always_ff @(posedge clk) begin
    if (rst) in_flight <= 1'b0;
    else if (mem_req_valid && mem_req_ready) in_flight <= 1'b1;
    else if (mem_rsp_valid) in_flight <= 1'b0;
  end

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) && !rst |-> !mem_req_valid && !addr_valid && !tag_valid && !done);

  // R6
  p_one_read_r6: assert property (@(posedge clk) disable iff (rst)
    in_flight |-> !mem_req_valid);

  // R7
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R8
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_data));

  // R8
  p_tag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    tag_valid && !tag_ready |=> tag_valid && $stable(tag_data));

  // R9
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  p_done_drained_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !addr_valid && !tag_valid && !in_flight);

endmodule

bind list_walker list_walker_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .done(done),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_data(addr_data),
  .tag_valid(tag_valid), .tag_ready(tag_ready), .tag_data(tag_data)
);

// File: tb/list_walker_tb_top.sv
module list_walker_tb_top;
  localparam int AW = 16;
  localparam int NL = 4;
  localparam int HB = 0;
  localparam int NO = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic done;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [AW-1:0] mem_rsp_data = '0;
  logic addr_valid, addr_ready = 1'b0;
  logic [AW-1:0] addr_data;
  logic tag_valid, tag_ready = 1'b0;
  logic tag_data;

  always #2 clk = ~clk;

  list_walker #(.ADDR_W(AW), .NUM_LISTS(NL), .HEAD_BASE(HB), .NEXT_OFS(NO),
                .FIFO_DEPTH(4)) dut_i (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_data(addr_data),
    .tag_valid(tag_valid), .tag_ready(tag_ready), .tag_data(tag_data)
  );

  int errors = 0;
  int checks = 0;
  int mem [256];
  int exp_reads[$];
  int exp_addrs[$];
  int exp_tags[$];
  bit pend = 0;
  int lat = 0;
  int pend_addr = 0;
  int done_cnt = 0;
  bit prev_av = 0, prev_ar = 0, prev_tv = 0, prev_tr = 0;
  int prev_ad = 0, prev_td = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural walk of the memory image
  task automatic build_expect();
    exp_reads.delete(); exp_addrs.delete(); exp_tags.delete();
    for (int i = 0; i < NL; i++) begin
      int p;
      exp_reads.push_back(HB + i);
      p = mem[HB + i];
      while (p != 0) begin
        exp_addrs.push_back(p);
        exp_tags.push_back(1);
        exp_reads.push_back(p + NO);
        p = mem[(p + NO) % 256];
      end
      exp_tags.push_back(0);
    end
  endtask

  // one clock: drive at falling edge, observe 1 ns later
  task automatic step(input int mode, input bit st);
    @(negedge clk);
    start = st;
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (lat <= 1) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = AW'(mem[pend_addr % 256]);
        pend = 0;
      end else lat--;
    end
    mem_req_ready = (mode == 0) ? 1'b1 : 1'($urandom % 2);
    addr_ready    = (mode == 0) ? 1'b1 : 1'($urandom % 3 != 0);
    tag_ready     = (mode == 0) ? 1'b1 : 1'($urandom % 2);
    #1;
    if (rst) return;
    // R8: stability while stalled
    if (prev_av && !prev_ar)
      chk(addr_valid && int'(addr_data) == prev_ad, "R8", "addr held", int'(addr_data), prev_ad);
    if (prev_tv && !prev_tr)
      chk(tag_valid && int'(tag_data) == prev_td, "R8", "tag held", int'(tag_data), prev_td);
    prev_av = addr_valid; prev_ar = addr_ready; prev_ad = int'(addr_data);
    prev_tv = tag_valid;  prev_tr = tag_ready;  prev_td = int'(tag_data);
    if (mem_req_valid && mem_req_ready) begin
      int e;
      e = (exp_reads.size() > 0) ? exp_reads.pop_front() : -1;
      chk(int'(mem_req_addr) == e, "R2", "read address (R4 next ptr)", int'(mem_req_addr), e);
      chk(!pend, "R6", "request while read in flight", 1, 0);
      pend = 1;
      pend_addr = int'(mem_req_addr);
      lat = (mode == 0) ? 1 : 1 + int'($urandom % 5);
    end
    if (addr_valid && addr_ready) begin
      int e;
      e = (exp_addrs.size() > 0) ? exp_addrs.pop_front() : -1;
      chk(int'(addr_data) == e, "R3", "value address", int'(addr_data), e);
    end
    if (tag_valid && tag_ready) begin
      int e;
      e = (exp_tags.size() > 0) ? exp_tags.pop_front() : -1;
      chk(int'(tag_data) == e, "R5", "tag order (1 continue, 0 exit)", int'(tag_data), e);
    end
    if (done) begin
      done_cnt++;
      chk(exp_tags.size() == 0 && exp_addrs.size() == 0 && exp_reads.size() == 0,
          "R9", "items left at done", exp_tags.size() + exp_addrs.size(), 0);
    end
  endtask

  task automatic run_walk(input int mode, input bit poke_start);
    int cyc;
    build_expect();
    done_cnt = 0;
    step(mode, 1'b1);
    cyc = 0;
    while (done_cnt == 0 && cyc < 4000) begin
      step(mode, poke_start && (cyc == 15 || cyc == 40));
      cyc++;
    end
    if (done_cnt == 0) chk(1'b0, "R9", "watchdog: done never seen", cyc, 0);
    for (int k = 0; k < 10; k++) begin
      step(mode, 1'b0);
      chk(!mem_req_valid, "R10", "request after done", int'(mem_req_valid), 0);
    end
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    chk(exp_tags.size() == 0, "R3", "tags missing", exp_tags.size(), 0);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 0;
    // image A: lists of 3, 0, 1, 2 nodes; node p holds next at p+1
    mem[0] = 16'h10; mem[1] = 0; mem[2] = 16'h40; mem[3] = 16'h50;
    mem[16'h11] = 16'h20; mem[16'h21] = 16'h30; mem[16'h31] = 0;
    mem[16'h41] = 0; mem[16'h51] = 16'h60; mem[16'h61] = 0;
    rst = 1'b1;
    for (int k = 0; k < 4; k++) step(0, 1'b0);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk(!mem_req_valid, "R1", "mem_req_valid after reset", int'(mem_req_valid), 0);
    chk(!addr_valid, "R1", "addr_valid after reset", int'(addr_valid), 0);
    chk(!tag_valid, "R1", "tag_valid after reset", int'(tag_valid), 0);
    chk(!done, "R1", "done after reset", int'(done), 0);

    run_walk(0, 1'b0);          // no stalls, latency 1
    run_walk(1, 1'b1);          // random stalls and latency, start pokes (R10)

    // image B: three empty lists and one list of five nodes
    for (int a = 0; a < 256; a++) mem[a] = 0;
    mem[2] = 16'h70;
    mem[16'h71] = 16'h80; mem[16'h81] = 16'h90;
    mem[16'h91] = 16'hA0; mem[16'hA1] = 16'hB0; mem[16'hB1] = 0;
    run_walk(1, 1'b0);
    run_walk(0, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL R9 global watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule